// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

The block collects per-pin interrupt events from six pin banks of up to 32 pins each and folds them into six interrupt groups, one per bank. Each group keeps a sticky source vector, an enable vector and a result view (source masked by enable). Each group drives one request line toward the processor's interrupt controller. A global block-enable register gates every group's line.

Software clears pending sources with a single write-1-to-clear store; it never needs a read-modify-write. Enables are changed through separate set and clear registers, so one pin's enable can change without touching its neighbours. The request line is a combinational function of the stored state. Clearing one pending pin therefore never drops a line while another enabled pin of the same group is still pending.

Groups carry the identifiers 8, 9, 10, 11, 12 and 26 and are stored in that order (slot 0 to 5). Banks 0, 1, 2, 3, 4 and 5 feed groups 11, 10, 9, 8, 12 and 26.

Top module: `gia_top`

## Requirements
- R1: After reset every source, enable and block-enable bit is 0, every register reads 0 and every request line is low.
- R2: A pin event sets its source bit on the next clock edge whether or not the bit is enabled, and the bit stays set until it is cleared by software.
- R3: Writing to a group's source register (offset 0) clears each source bit written with 1 and leaves each bit written with 0 unchanged.
- R4: When a pin event and a write-1-to-clear hit the same source bit in the same cycle, the bit ends up set.
- R5: Writing 1 to a bit of the enable-set register (offset 1) sets only that enable bit. Writing 1 to a bit of the enable-clear register (offset 2) clears only that bit. Reading either register returns the current enable vector.
- R6: The result register (offset 3) reads as source AND enable, and writes to it have no effect.
- R7: The request line of a group is high exactly when its result is non-zero and the block-enable bit at the group's identifier position is 1. Groups 8, 9, 10, 11, 12 and 26 drive request outputs 0, 1, 2, 3, 4 and 18, and outputs 5 to 17 stay low.
- R8: If enabled sources of a group remain set after a clear write, the group's request line stays high through the clear without a low cycle.
- R9: Bank b feeds group 11, 10, 9, 8, 12 or 26 for b = 0 to 5, and the event on bit i of a bank sets bit i of that group's source.
- R10: The block-enable register at word address 24 is read/write only in bit positions 8, 9, 10, 11, 12 and 26. All other bits read 0.
- R11: Group slot s (ids 8, 9, 10, 11, 12, 26 in slot order 0 to 5) occupies word addresses 4s to 4s+3, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinEvent | input | 192 | Per-pin event pulses; bank b bit i at index 32b+i |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Word address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| irqOut | output | 19 | Request lines toward the interrupt controller |

## Verification
The bench focuses on the clear paths. It checks that a 0 written to the source register leaves pending bits alone; a design that wrote the data through would wipe them. It checks that an event arriving in the same cycle as its clear survives; a design that gave the clear priority would lose it. It also watches the request line in every cycle of a partial clear; a registered or pulsed request would show a low gap there. Finally, it walks each bank through to its output line, including the sparse output 18 and the reversed order of banks 0 to 3, so that a swapped table shows up as the wrong line rising.

// File: rtl/gia_pkg.sv
package gia_pkg;
  localparam int NUM_GROUPS = 6;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 5;
  localparam int IRQ_W      = 19;
  localparam int BLK_ADDR   = 24;

  typedef enum logic [1:0] {
    REG_SRC  = 2'd0,
    REG_ESET = 2'd1,
    REG_ECLR = 2'd2,
    REG_RES  = 2'd3
  } regKind_e;

  typedef struct packed {
    logic [NUM_GROUPS-1:0] srcClr;
    logic [NUM_GROUPS-1:0] enSet;
    logic [NUM_GROUPS-1:0] enClr;
    logic                  blkWr;
    logic [2:0]            rdSlot;
    regKind_e              rdKind;
    logic                  rdHit;
    logic                  rdBlk;
  } strobes_t;

  // slot order 0..5 holds group ids 8,9,10,11,12,26
  function automatic int groupIdOf(int slot);
    return (slot < 5) ? (8 + slot) : 26;
  endfunction

  // banks 0..3 feed groups 11..8 (slots 3..0), banks 4,5 map straight;
  // the mapping is its own inverse
  function automatic int slotOfBank(int bank);
    return (bank < 4) ? (3 - bank) : bank;
  endfunction

  function automatic int irqIndexOf(int slot);
    return (slot < 5) ? slot : 18;
  endfunction

  function automatic logic [REG_W-1:0] blkMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_GROUPS; s++) m[groupIdOf(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gia_ctrl.sv
module gia_ctrl
  import gia_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);
  logic [2:0] slotSel;
  regKind_e   kindSel;
  logic       slotHit;
  logic       blkHit;

  always_comb begin
    slotSel = addr[ADDR_W-1:2];
    kindSel = regKind_e'(addr[1:0]);
    slotHit = (int'(slotSel) < NUM_GROUPS);
    blkHit  = (int'(addr) == BLK_ADDR);
  end

  always_comb begin
    stb = '0;
    stb.rdSlot = slotSel;
    stb.rdKind = kindSel;
    stb.rdHit  = slotHit;
    stb.rdBlk  = blkHit;
    stb.blkWr  = wrEn && blkHit;
    for (int s = 0; s < NUM_GROUPS; s++) begin
      if (wrEn && slotHit && int'(slotSel) == s) begin
        stb.srcClr[s] = (kindSel == REG_SRC);
        stb.enSet[s]  = (kindSel == REG_ESET);
        stb.enClr[s]  = (kindSel == REG_ECLR);
      end
    end
  end

  // R11: a write reaches at most one register
  p_single_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.srcClr, stb.enSet, stb.enClr, stb.blkWr}));

  // R6: a write to a result address produces no strobe
  p_result_readonly_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[1:0] == 2'd3 && !blkHit) |->
      ({stb.srcClr, stb.enSet, stb.enClr} == '0));
endmodule

// File: rtl/gia_datapath.sv
module gia_datapath
  import gia_pkg::*;
#(
  parameter int PIN_W = REG_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_GROUPS*PIN_W-1:0] pinEvent,
  input  logic [REG_W-1:0]            wrData,
  input  strobes_t                    stb,
  output logic [REG_W-1:0]            rdData,
  output logic [IRQ_W-1:0]            irqOut
);
  localparam logic [REG_W-1:0] BLK_MASK = blkMask();

  logic [PIN_W-1:0] srcQ   [NUM_GROUPS];
  logic [PIN_W-1:0] enQ    [NUM_GROUPS];
  logic [PIN_W-1:0] resVec [NUM_GROUPS];
  logic [REG_W-1:0] blkQ;
  logic [NUM_GROUPS-1:0] grpReq;

  always_ff @(posedge clk) begin
    if (!rstN) blkQ <= '0;
    else if (stb.blkWr) blkQ <= wrData & BLK_MASK;
  end

  for (genvar s = 0; s < NUM_GROUPS; s++) begin : g_group
    localparam int BANK = slotOfBank(s);
    localparam int GID  = groupIdOf(s);
    localparam int IDX  = irqIndexOf(s);
    logic [PIN_W-1:0] evtIn;
    logic [PIN_W-1:0] clrMask;
    logic [PIN_W-1:0] setMask;
    logic [PIN_W-1:0] offMask;

    assign evtIn   = pinEvent[BANK*PIN_W +: PIN_W];
    assign clrMask = stb.srcClr[s] ? wrData[PIN_W-1:0] : '0;
    assign setMask = stb.enSet[s]  ? wrData[PIN_W-1:0] : '0;
    assign offMask = stb.enClr[s]  ? wrData[PIN_W-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcQ[s] <= '0;
        enQ[s]  <= '0;
      end else begin
        srcQ[s] <= (srcQ[s] & ~clrMask) | evtIn;   // event wins over clear
        enQ[s]  <= (enQ[s] | setMask) & ~offMask;
      end
    end

    assign resVec[s] = srcQ[s] & enQ[s];
    assign grpReq[s] = (|resVec[s]) & blkQ[GID];

    // R2: a source bit drops only under a clear strobe
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
      !stb.srcClr[s] |=> ((srcQ[s] & $past(srcQ[s])) == $past(srcQ[s])));

    // R4: an event in a clear cycle is kept
    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
      stb.srcClr[s] |=> ((srcQ[s] & $past(evtIn)) == $past(evtIn)));

    // R5: set bits appear, cleared bits vanish
    p_enable_set_r5: assert property (@(posedge clk) disable iff (!rstN)
      stb.enSet[s] |=> ((enQ[s] & $past(wrData[PIN_W-1:0])) == $past(wrData[PIN_W-1:0])));
    p_enable_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
      stb.enClr[s] |=> ((enQ[s] & $past(wrData[PIN_W-1:0])) == '0));

    // R8: remaining enabled pending bits keep the line up through a clear
    p_reassert_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stb.srcClr[s] && ((resVec[s] & ~wrData[PIN_W-1:0]) != '0) && blkQ[GID] && !stb.blkWr
       && !stb.enClr[s]) |=> irqOut[IDX]);
  end

  always_comb begin
    irqOut = '0;
    for (int s = 0; s < NUM_GROUPS; s++) irqOut[irqIndexOf(s)] = grpReq[s];
  end

  always_comb begin
    rdData = '0;
    if (stb.rdBlk) rdData = blkQ;
    else if (stb.rdHit) begin
      for (int s = 0; s < NUM_GROUPS; s++) begin
        if (int'(stb.rdSlot) == s) begin
          case (stb.rdKind)
            REG_SRC:  rdData[PIN_W-1:0] = srcQ[s];
            REG_ESET,
            REG_ECLR: rdData[PIN_W-1:0] = enQ[s];
            default:  rdData[PIN_W-1:0] = resVec[s];
          endcase
        end
      end
    end
  end

  // R7: outputs with no group behind them never rise
  p_unused_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[17:5] == '0);
endmodule

// File: rtl/gia_top.sv
module gia_top
  import gia_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_GROUPS*REG_W-1:0] pinEvent,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wrData,
  output logic [REG_W-1:0]            rdData,
  output logic [IRQ_W-1:0]            irqOut
);
  strobes_t stb;

  gia_ctrl i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  gia_datapath #(.PIN_W(REG_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinEvent (pinEvent),
    .wrData   (wrData),
    .stb      (stb),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/test_gia_top.sv
module test_gia_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [191:0] pinEvent = '0;
  logic         wrEn = 1'b0;
  logic [4:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic [18:0]  irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  gia_top i_gia_top (
    .clk(clk), .rstN(rstN), .pinEvent(pinEvent), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // independent tables: slot per bank, output index per slot
  function automatic int bankSlot(int b);
    int t[6] = '{3, 2, 1, 0, 4, 5};
    return t[b];
  endfunction
  function automatic int slotIrq(int s);
    int t[6] = '{0, 1, 2, 3, 4, 18};
    return t[s];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock with optional write and events, driven at the falling edge
  task automatic cyc(logic we, logic [4:0] a, logic [31:0] d, logic [191:0] ev);
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; pinEvent = ev;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; pinEvent = '0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    cyc(1'b1, a, d, '0);
  endtask

  task automatic pulse(int bank, int bitPos);
    logic [191:0] ev = '0;
    ev[bank*32 + bitPos] = 1'b1;
    cyc(1'b0, 5'd0, 32'd0, ev);
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic clearAll();
    for (int s = 0; s < 6; s++) begin
      wr(5'(4*s), 32'hFFFF_FFFF);
      wr(5'(4*s + 2), 32'hFFFF_FFFF);
    end
    wr(5'd24, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), v);
      chk("R1", $sformatf("read addr %0d after reset", a), v, 32'd0);
    end
    chk("R1", "irq after reset", {13'd0, irqOut}, 32'd0);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    pulse(0, 5);
    rd(5'd12, v); chk("R2", "bank0 bit5 latched unenabled (group 11)", v, 32'h20);
    rd(5'd15, v); chk("R6", "result with enable off", v, 32'd0);
    chk("R2", "no irq when unenabled", {13'd0, irqOut}, 32'd0);
    repeat (3) @(negedge clk);
    rd(5'd12, v); chk("R2", "source stays set", v, 32'h20);
    pulse(3, 0);
    rd(5'd0, v); chk("R9", "bank3 bit0 into group 8", v, 32'h1);
    pulse(5, 31);
    rd(5'd20, v); chk("R9", "bank5 bit31 into group 26", v, 32'h8000_0000);
    rd(5'd28, v); chk("R11", "unmapped address reads zero", v, 32'd0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(5'd12, 32'h0);
    rd(5'd12, v); chk("R3", "write 0 leaves source", v, 32'h20);
    wr(5'd12, 32'hFFFF_FFDF);
    rd(5'd12, v); chk("R3", "write 1 elsewhere leaves bit", v, 32'h20);
    wr(5'd12, 32'h20);
    rd(5'd12, v); chk("R3", "write 1 clears bit", v, 32'd0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(5'd13, 32'hF0);
    rd(5'd13, v); chk("R5", "enable via set reg", v, 32'hF0);
    rd(5'd14, v); chk("R5", "enable via clear reg", v, 32'hF0);
    wr(5'd13, 32'h01);
    rd(5'd13, v); chk("R5", "set leaves others", v, 32'hF1);
    wr(5'd14, 32'h30);
    rd(5'd14, v); chk("R5", "clear only written bits", v, 32'hC1);
    clearAll();
  endtask

  task automatic t_result_irq();
    logic [31:0] v;
    wr(5'd1, 32'h3);
    pulse(3, 0); pulse(3, 1); pulse(3, 2);
    rd(5'd3, v); chk("R6", "result = source & enable", v, 32'h3);
    chk("R7", "irq gated by block enable", {13'd0, irqOut}, 32'd0);
    wr(5'd24, 32'h100);
    chk("R7", "group 8 irq on output 0", {13'd0, irqOut}, 32'h1);
    rd(5'd24, v); chk("R10", "block enable readback", v, 32'h100);
    wr(5'd3, 32'hFFFF_FFFF);
    rd(5'd0, v); chk("R6", "result write ignored (source)", v, 32'h7);
    rd(5'd1, v); chk("R6", "result write ignored (enable)", v, 32'h3);
    wr(5'd24, 32'hFFFF_FFFF);
    rd(5'd24, v); chk("R10", "only group-id bits stick", v, 32'h0400_1F00);
  endtask

  task automatic t_reassert();
    logic gap = 1'b0;
    @(negedge clk);
    wrEn = 1'b1; addr = 5'd0; wrData = 32'h1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1 if (!irqOut[0]) gap = 1'b1;
      if (k == 0) begin @(negedge clk); wrEn = 1'b0; end
    end
    chk("R8", "no low cycle after partial clear", {31'd0, gap}, 32'd0);
    wr(5'd0, 32'h2);
    chk("R8", "line drops when last enabled clears", {31'd0, irqOut[0]}, 32'd0);
    clearAll();
  endtask

  task automatic t_race();
    logic [31:0] v;
    logic [191:0] ev = '0;
    pulse(0, 7);
    ev[7] = 1'b1;
    cyc(1'b1, 5'd12, 32'h80, ev);
    rd(5'd12, v); chk("R4", "event beats same-cycle clear", v, 32'h80);
    clearAll();
  endtask

  task automatic t_mapping();
    wr(5'd24, 32'hFFFF_FFFF);
    for (int b = 0; b < 6; b++) begin
      int s = bankSlot(b);
      wr(5'(4*s + 1), 32'h1);
      pulse(b, 0);
      chk("R7", $sformatf("bank %0d line", b), {13'd0, irqOut}, 32'(1) << slotIrq(s));
      wr(5'(4*s), 32'h1);
      wr(5'(4*s + 2), 32'h1);
    end
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_latch();
    t_w1c();
    clearAll();
    t_enable();
    t_result_irq();
    t_reassert();
    t_race();
    t_mapping();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule